// File: doc/BRIEF.md
# Double-Buffered SPI Master/Slave Controller

This block is a register-mapped SPI peripheral that acts either as the clock-driving master or as a clocked slave. A 16-bit shift engine moves one bit out on the data-out pin and one bit in from the data-in pin on every serial clock pulse. Each word is 8 or 16 pulses long, the most significant bit goes first, and the clock is mode 0: it idles low and the data is sampled on the rising edge. A transmit holding register and a receive holding register sit on either side of the shift engine. Both are reached through one data address: a write fills the transmit holder and a read drains the receive holder.

Software selects the role, the word size and the master clock ratio in a control register. A status register carries the enable, the buffer-full flags, the overflow flag and a transfer-complete interrupt flag. In master mode, writing a word starts a transfer. In slave mode, the pin inputs pass through synchronizers and the block follows the external clock while the active-low select is held low. If a word completes while the receive holder is still full, the new word is dropped and the block freezes until software has cleared the overflow flag and has read the data address.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset, the control register and the status register read as zero, `sck_o` is low and `irq_o` is low.
- R2: When the block is enabled (status bit 15 = 1) with master mode selected (control bit 5 = 1), a write to the data address (sel 2) starts a transfer. `sck_o` idles low and has a period of 2*(div+1) system clocks, where div is control bits [3:0]. The word is sent MSB first and is 8 bits long when control bit 10 = 0, 16 bits long when it is 1.
- R3: When a word completes while the receive holder is full (status bit 0 = 1), the overflow bit (status bit 6) sets, the new word is discarded and the receive holder keeps its previous word.
- R4: While overflow is pending, no clock edge is generated or followed and no transfer starts. Shifting resumes only after software has written 0 to status bit 6 and has read the data address, in either order.
- R5: Status bit 1 (transmit full) sets on a write to the data address and clears when the word moves into the shift engine. A write made while that bit is set is ignored.
- R6: At the end of a transfer, the shifted-in word moves to the receive holder and status bit 0 sets. A read of the data address returns that word and clears bit 0. A word held in the transmit holder moves into the shift engine once the previous word has finished.
- R7: Each completed word sets status bit 2. `irq_o` is high only while that bit and control bit 8 are both 1. Writing 0 to status bit 2 clears it.
- R8: In 8-bit mode, only the low byte of a written word is sent, and the receive word reads with bits [15:8] as zero.
- R9: In slave mode (control bit 5 = 0), `sck_oe` is low. While `ssel_n_i` is low, the block samples `sdi_i` on rising edges of `sck_i`, presents the next bit on `sdo_o` after each falling edge, and completes a word after 8 or 16 falling edges.
- R10: In slave mode, raising `ssel_n_i` in the middle of a word discards the partial word: no receive word is delivered and the next word starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of the data address drains the receive holder |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Transfer-complete interrupt |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | High when `sck_o` drives the clock line |
| ssel_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
The hardest state to reach is the overflow lockout. It needs two completed words with no read between them, and then a proof that nothing moves until both release conditions have been met. The stimulus runs two master transfers back to back against a bench-modelled peer. It queues a third word and counts clock edges while first only the flag is cleared and then the data address is read. A second hard case is a write that lands while the transmit holder is full during a running transfer; this is reached by writing three words in quick succession and checking the order of the bits the peer receives.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  localparam int unsigned CTRL_MASTER = 5;
  localparam int unsigned CTRL_IE     = 8;
  localparam int unsigned CTRL_WIDE   = 10;

  localparam int unsigned STAT_EN   = 15;
  localparam int unsigned STAT_OVF  = 6;
  localparam int unsigned STAT_BUSY = 3;
  localparam int unsigned STAT_IRQF = 2;
  localparam int unsigned STAT_TXF  = 1;
  localparam int unsigned STAT_RXF  = 0;

  // keep only the active part of a word for the chosen size
  function automatic logic [WORD_W-1:0] fit_word(logic [WORD_W-1:0] w, logic wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  // one falling-edge shift step, MSB first
  function automatic logic [WORD_W-1:0] shift_step(logic [WORD_W-1:0] sr, logic b, logic wide);
    return fit_word({sr[WORD_W-2:0], b}, wide);
  endfunction

  function automatic logic [CNT_W-1:0] word_bits(logic wide);
    return wide ? CNT_W'(16) : CNT_W'(8);
  endfunction

endpackage

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_dbuf_clkgen.sv
module spi_dbuf_clkgen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;

  assign tick   = run_i && (cnt_q >= half_i);
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the clock returns to its idle low level once the run request drops
  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sck_o);
endmodule

// File: rtl/spi_dbuf_shift.sv
module spi_dbuf_shift
  import spi_dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              abort_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] next_word_o,
  output logic              done_o,
  output logic              idle_o
);
  logic [WORD_W-1:0] sr_q;
  logic              cap_q;
  logic              half_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_idx;
  logic              step;

  assign last_idx    = word_bits(wide_i) - 1'b1;
  assign step        = fall_i && half_q && !abort_i;
  assign done_o      = step && (cnt_q == last_idx);
  assign next_word_o = shift_step(sr_q, cap_q, wide_i);
  assign sdo_o       = wide_i ? sr_q[15] : sr_q[7];
  assign word_o      = sr_q;
  assign idle_o      = (cnt_q == '0) && !half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= load_word_i;
    end else if (step) begin
      sr_q <= next_word_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else if (rise_i && !half_q) begin
      cap_q  <= sdi_i;
      half_q <= 1'b1;
    end else if (step) begin
      half_q <= 1'b0;
      cnt_q  <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: the bit counter stays inside the selected word length
  p_cnt_in_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < word_bits(wide_i));
  // R10: an abort leaves the engine at the start of a word
  p_abort_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> idle_o);
  // R6: a new word is only loaded between words
  p_load_between_words_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> idle_o);
endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_o,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        ssel_n_i,
  input  logic        sdi_i,
  output logic        sdo_o
);
  localparam logic [15:0] CTRL_MASK =
    (16'(1) << CTRL_WIDE) | (16'(1) << CTRL_IE) | (16'(1) << CTRL_MASTER) |
    16'((1 << DIV_W) - 1);

  logic [15:0]       ctrl_q;
  logic              en_q, ovf_q, unread_q, irqf_q, txf_q, rxf_q, busy_q;
  logic [WORD_W-1:0] txbuf_q, rxbuf_q;
  logic              sck_prev_q;

  logic master, wide, ie, lock;
  logic wr_ctrl, wr_stat, wr_data, rd_data;
  logic s_sck, s_ssel, s_sdi;
  logic m_rise, m_fall, s_rise, s_fall, rise, fall;
  logic abort, sdi_sel, load_go;
  logic sh_done, sh_idle;
  logic [WORD_W-1:0] sh_word, sh_next;
  logic ovf_event, rx_take;
  logic [15:0] stat_w;

  assign master = ctrl_q[CTRL_MASTER];
  assign wide   = ctrl_q[CTRL_WIDE];
  assign ie     = ctrl_q[CTRL_IE];
  assign lock   = ovf_q || unread_q;

  assign wr_ctrl = bus_wr && (bus_sel == REG_CTRL);
  assign wr_stat = bus_wr && (bus_sel == REG_STAT);
  assign wr_data = bus_wr && (bus_sel == REG_DATA);
  assign rd_data = bus_rd && (bus_sel == REG_DATA);

  // slave-side pins
  spi_dbuf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sck_i, ssel_n_i, sdi_i}),
    .q_o   ({s_sck, s_ssel, s_sdi})
  );

  // master clock
  spi_dbuf_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_q && !lock),
    .half_i (ctrl_q[DIV_W-1:0]),
    .sck_o  (sck_o),
    .rise_o (m_rise),
    .fall_o (m_fall)
  );

  assign s_rise  = en_q && !master && !lock && !s_ssel && s_sck && !sck_prev_q;
  assign s_fall  = en_q && !master && !lock && !s_ssel && !s_sck && sck_prev_q;
  assign rise    = master ? m_rise : s_rise;
  assign fall    = master ? m_fall : s_fall;
  assign abort   = !en_q || (!master && s_ssel);
  assign sdi_sel = master ? sdi_i : s_sdi;
  assign load_go = en_q && txf_q && !lock && sh_idle && (!master || !busy_q);

  spi_dbuf_shift i_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .wide_i      (wide),
    .load_i      (load_go),
    .load_word_i (txbuf_q),
    .rise_i      (rise),
    .fall_i      (fall),
    .abort_i     (abort),
    .sdi_i       (sdi_sel),
    .sdo_o       (sdo_o),
    .word_o      (sh_word),
    .next_word_o (sh_next),
    .done_o      (sh_done),
    .idle_o      (sh_idle)
  );

  assign ovf_event = sh_done && rxf_q;
  assign rx_take   = sh_done && !rxf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      en_q       <= 1'b0;
      ovf_q      <= 1'b0;
      unread_q   <= 1'b0;
      irqf_q     <= 1'b0;
      txf_q      <= 1'b0;
      rxf_q      <= 1'b0;
      busy_q     <= 1'b0;
      txbuf_q    <= '0;
      rxbuf_q    <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= s_sck;
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr_stat) en_q <= bus_wdata[STAT_EN];

      if (ovf_event)                          ovf_q <= 1'b1;
      else if (wr_stat && !bus_wdata[STAT_OVF]) ovf_q <= 1'b0;

      if (ovf_event)    unread_q <= 1'b1;
      else if (rd_data) unread_q <= 1'b0;

      if (sh_done)                             irqf_q <= 1'b1;
      else if (wr_stat && !bus_wdata[STAT_IRQF]) irqf_q <= 1'b0;

      if (rx_take) begin
        rxbuf_q <= sh_next;
        rxf_q   <= 1'b1;
      end else if (rd_data) begin
        rxf_q   <= 1'b0;
      end

      if (load_go) begin
        txf_q <= 1'b0;
      end else if (wr_data && !txf_q) begin
        txbuf_q <= fit_word(bus_wdata, wide);
        txf_q   <= 1'b1;
      end

      if (!en_q || !master) busy_q <= 1'b0;
      else if (load_go)     busy_q <= 1'b1;
      else if (sh_done)     busy_q <= 1'b0;
    end
  end

  always_comb begin
    stat_w            = '0;
    stat_w[STAT_EN]   = en_q;
    stat_w[STAT_OVF]  = ovf_q;
    stat_w[STAT_BUSY] = master ? busy_q : !sh_idle;
    stat_w[STAT_IRQF] = irqf_q;
    stat_w[STAT_TXF]  = txf_q;
    stat_w[STAT_RXF]  = rxf_q;
  end

  always_comb begin
    unique case (reg_sel_e'(bus_sel))
      REG_CTRL: bus_rdata = ctrl_q;
      REG_STAT: bus_rdata = stat_w;
      REG_DATA: bus_rdata = rxbuf_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o  = irqf_q && ie;
  assign sck_oe = en_q && master;

  // R3: a word arriving on a full holder is dropped and flagged
  p_ovf_drops_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf_q && $stable(rxbuf_q));
  // R4: the shift engine is frozen during lockout
  p_locked_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(sh_word));
  // R4: no edge reaches the engine during lockout
  p_locked_no_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !(rise || fall));
  // R5: a write onto a full transmit holder leaves it untouched
  p_txf_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && txf_q |=> $stable(txbuf_q));
  // R7: every finished word raises the interrupt flag
  p_done_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> irqf_q);
  // R8: narrow words arrive with an empty upper byte
  p_narrow_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take && !wide |=> rxbuf_q[15:8] == 8'h00);
  // R2: the master clock only toggles during a master transfer
  p_sck_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !sck_o);
endmodule

// File: tb/test_spi_dbuf_ctrl.sv
`timescale 1ns/1ps
module test_spi_dbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o, sck_o, sck_oe, sdo_o;
  logic        sck_i = 1'b0, ssel_n_i = 1'b1, drv_sdi = 1'b0;
  logic        use_peer = 1'b0;
  logic        sdi_w;

  logic [15:0] peer_word = '0;
  logic [15:0] peer_rx = '0;
  int          peer_falls = 0, peer_base = 0;
  int          cyc = 0, last_rise = 0, sck_per = 0, sck_rises = 0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  localparam int H = 6;

  always #2 clk = ~clk;
  always @(negedge clk) cyc++;

  spi_dbuf_ctrl i_spi_dbuf_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ssel_n_i(ssel_n_i),
    .sdi_i(sdi_w), .sdo_o(sdo_o)
  );

  // bench peer slave for master transfers: mode 0, MSB first
  always @(posedge sck_o) begin
    peer_rx   <= {peer_rx[14:0], sdo_o};
    sck_per   = cyc - last_rise;
    last_rise = cyc;
    sck_rises++;
  end
  always @(negedge sck_o) peer_falls++;

  assign sdi_w = use_peer ?
    (((peer_falls - peer_base) < 16) ? peer_word[4'(15 - (peer_falls - peer_base))] : 1'b0)
    : drv_sdi;

  function automatic logic [15:0] fit(logic [15:0] w, bit wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_xfer(bit wide, int div, logic [15:0] tx, logic [15:0] pw);
    logic [15:0] got;
    int bits;
    bits = wide ? 16 : 8;
    use_peer = 1'b1;
    bus_write(2'd0, 16'((int'(wide) << 10) | (1 << 5) | div));
    peer_word = wide ? pw : {pw[7:0], 8'h00};
    peer_base = peer_falls;
    bus_write(2'd2, tx);
    wait_cyc(2 * (div + 1) * bits + 8);
    bus_read(2'd2, got);
    check(wide ? "R6 rx word" : "R8 narrow rx word", got, fit(pw, wide));
    check(wide ? "R2 peer got wide" : "R8 peer got low byte",
          wide ? peer_rx : {8'h00, peer_rx[7:0]}, fit(tx, wide));
    check("R2 sck period", 16'(sck_per), 16'(2 * (div + 1)));
    bus_write(2'd1, 16'h8000);
  endtask

  task automatic s_xfer(bit wide, logic [15:0] tx, logic [15:0] mw);
    logic [15:0] got, seen;
    int bits;
    bits = wide ? 16 : 8;
    use_peer = 1'b0;
    seen = '0;
    bus_write(2'd0, 16'(int'(wide) << 10));
    bus_write(2'd2, tx);
    wait_cyc(4);
    ssel_n_i = 1'b0;
    for (int i = 0; i < bits; i++) begin
      drv_sdi = mw[bits - 1 - i];
      wait_cyc(H);
      seen = {seen[14:0], sdo_o};
      sck_i = 1'b1;
      wait_cyc(H);
      sck_i = 1'b0;
    end
    wait_cyc(8);
    ssel_n_i = 1'b1;
    wait_cyc(4);
    bus_read(2'd2, got);
    check("R9 slave rx", got, fit(mw, wide));
    check("R9 slave sdo", seen, fit(tx, wide));
    bus_write(2'd1, 16'h8000);
  endtask

  initial begin
    logic [15:0] r;
    int          r0;
    void'($urandom(32'd1234));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    bus_read(2'd1, r); check("R1 status", r, 16'h0000);
    bus_read(2'd0, r); check("R1 control", r, 16'h0000);
    check("R1 sck", {15'd0, sck_o}, 16'd0);
    check("R1 irq", {15'd0, irq_o}, 16'd0);

    bus_write(2'd1, 16'h8000);

    // R2/R6/R8 random master transfers
    for (int k = 0; k < 20; k++) begin
      m_xfer(1'($urandom), int'($urandom % 4), 16'($urandom), 16'($urandom));
    end

    // R5 write onto full transmit holder is ignored; order preserved (R6)
    use_peer = 1'b1;
    bus_write(2'd0, 16'h0021);
    peer_word = 16'hA55A;
    peer_base = peer_falls;
    bus_write(2'd2, 16'h0081);
    wait_cyc(3);
    bus_write(2'd2, 16'h0042);
    bus_write(2'd2, 16'h0099);
    bus_read(2'd1, r);
    check("R5 tx full flag", {15'd0, r[1]}, 16'd1);
    wait_cyc(40);
    bus_read(2'd2, r); check("R6 first rx", r, 16'h00A5);
    wait_cyc(40);
    bus_read(2'd2, r); check("R6 second rx", r, 16'h005A);
    check("R5 sent order", peer_rx, 16'h8142);
    bus_write(2'd1, 16'h8000);

    // R3/R4 overflow lockout
    bus_write(2'd0, 16'h0020);
    peer_word = 16'h3C00; peer_base = peer_falls;
    bus_write(2'd2, 16'h0011);
    wait_cyc(30);
    peer_word = 16'hC300; peer_base = peer_falls;
    bus_write(2'd2, 16'h0022);
    wait_cyc(30);
    bus_read(2'd1, r);
    check("R3 ovf flag", {15'd0, r[6]}, 16'd1);
    r0 = sck_rises;
    bus_write(2'd2, 16'h0033);
    wait_cyc(40);
    check("R4 frozen", 16'(sck_rises - r0), 16'd0);
    bus_read(2'd1, r);
    check("R4 tx waits", {15'd0, r[1]}, 16'd1);
    bus_write(2'd1, 16'h8000);
    wait_cyc(40);
    check("R4 still frozen before read", 16'(sck_rises - r0), 16'd0);
    peer_word = 16'h5A00; peer_base = peer_falls;
    bus_read(2'd2, r);
    check("R3 old word kept", r, 16'h003C);
    wait_cyc(30);
    check("R4 resumed", {8'h00, peer_rx[7:0]}, 16'h0033);
    bus_read(2'd2, r);
    check("R4 resumed rx", r, 16'h005A);
    bus_write(2'd1, 16'h8000);

    // R7 interrupt gating
    peer_word = 16'h0000; peer_base = peer_falls;
    bus_write(2'd2, 16'h000F);
    wait_cyc(30);
    check("R7 irq masked", {15'd0, irq_o}, 16'd0);
    bus_read(2'd1, r);
    check("R7 flag set", {15'd0, r[2]}, 16'd1);
    bus_write(2'd0, 16'h0120);
    wait_cyc(1);
    check("R7 irq on", {15'd0, irq_o}, 16'd1);
    bus_write(2'd1, 16'h8000);
    wait_cyc(1);
    check("R7 irq cleared", {15'd0, irq_o}, 16'd0);
    bus_read(2'd2, r);

    // R9 slave transfers
    use_peer = 1'b0;
    bus_write(2'd0, 16'h0000);
    wait_cyc(2);
    check("R9 sck_oe low", {15'd0, sck_oe}, 16'd0);
    for (int k = 0; k < 10; k++) begin
      s_xfer(1'($urandom), 16'($urandom), 16'($urandom));
    end

    // R10 slave abort mid-word
    bus_write(2'd2, 16'h0000);
    wait_cyc(4);
    ssel_n_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      drv_sdi = 1'b1;
      wait_cyc(H); sck_i = 1'b1;
      wait_cyc(H); sck_i = 1'b0;
    end
    wait_cyc(H);
    ssel_n_i = 1'b1;
    wait_cyc(10);
    bus_read(2'd1, r);
    check("R10 no partial word", {15'd0, r[0]}, 16'd0);
    s_xfer(1'b0, 16'h00E1, 16'h0096);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule